// File: doc/BRIEF.md
# In-Order Completion Reorder Buffer

This block is a circular reorder buffer for a small out-of-order core with a 16-bit datapath and eight architectural registers. The decode side claims one slot per instruction through an allocate port. That port returns the slot index the instruction carries through execution. Each slot records whether it is in use, the kind of operation, whether a result has arrived, the destination register and the 16-bit result.

Execution units report results through a completion port, addressed by slot index. The port stores the data and marks the slot as done. A head pointer names the oldest outstanding slot, and entries leave only from there. When the head slot is done, it is released on the next clock edge. For one cycle the block then shows the slot index, destination and data, with a register-write strobe for kinds that produce a register result. After that the head moves on by one, wrapping at the depth.

The release side is a two-state machine. RT_IDLE means nothing was released at the last edge. RT_EMIT means the outputs carry a released entry. Both states move to RT_EMIT when the head slot is in use and done, and to RT_IDLE otherwise. The synchronous clear forces RT_IDLE. The depth is a parameter.

Top module: `rob_inorder`

## Requirements
- R1: After reset or a synchronous clear, no slot is in use, `alloc_idx` reads 0, `rob_full` is 0 and `ret_fire` is 0.
- R2: `alloc_idx` shows the slot the next accepted allocation receives. Each accepted allocation (`alloc_ok`=1 at a clock edge) advances it by one.
- R3: An allocated slot stays in use until released. When the slot at the allocation pointer is still in use, `rob_full`=1, `alloc_ok`=0 and the pointer does not move.
- R4: A completion (`cmp_vld`) addressed to an in-use slot records `cmp_data` and marks the slot done. A completion addressed to a slot not in use has no effect.
- R5: Slots are released strictly in allocation order. A younger slot that is done waits until every older slot has been released.
- R6: When the head slot is done at a clock edge, the next cycle shows `ret_fire`=1 for exactly one cycle, with that slot's `ret_idx`, `ret_dst` and `ret_data`. A run of done slots leaves on consecutive cycles, one per cycle.
- R7: Kind encoding on `alloc_kind`: 0 = arithmetic and 1 = load produce a register result and release with `ret_we`=1. 2 = store and 3 = branch release with `ret_fire`=1 and `ret_we`=0.
- R8: A released slot is free again from the cycle after its release edge, so `rob_full` drops there.
- R9: `clr` takes priority over an allocation or completion in the same cycle. Neither takes effect, and no slot present before the clear is released afterwards.
- R10: Both the allocation pointer and the head pointer wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all slots and pointers |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_kind | input | 2 | Operation kind of the new instruction |
| alloc_dst | input | 3 | Destination register of the new instruction |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | IDX_W | Slot index given to the new instruction |
| rob_full | output | 1 | Slot at the allocation pointer is still in use |
| cmp_vld | input | 1 | Execution result present |
| cmp_idx | input | IDX_W | Slot the result belongs to |
| cmp_data | input | 16 | Result value |
| ret_fire | output | 1 | An entry is being released |
| ret_we | output | 1 | Register-file write strobe |
| ret_idx | output | IDX_W | Slot index of the released entry |
| ret_dst | output | 3 | Destination register of the released entry |
| ret_data | output | 16 | Result of the released entry |

## Verification
Results arrive in reverse program order, so an in-order buffer is told apart from one that releases any done slot. The bench also checks that nothing leaves until the oldest result lands, and then that the whole run drains on consecutive cycles. A full ring filled from a non-zero start makes both pointers wrap. It also shows that a refused allocation leaves the pointer alone and that one release frees the full condition. A clear issued together with an allocation and a completion checks the priority of the clear. A completion sent to an idle slot checks that it is ignored. Mixing all four kinds checks that the write strobe follows the kind while every entry is still released.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int DATA_W = 16;
    localparam int REG_W  = 3;

    typedef enum logic [1:0] {
        OP_ALU    = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STORE  = 2'd2,
        OP_BRANCH = 2'd3
    } op_kind_t;

    typedef struct packed {
        logic              busy;
        op_kind_t          kind;
        logic              done;
        logic [REG_W-1:0]  dst;
        logic [DATA_W-1:0] data;
    } rob_entry_t;

    typedef enum logic {
        RT_IDLE = 1'b0,
        RT_EMIT = 1'b1
    } rt_state_t;

    function automatic logic writes_reg(op_kind_t k);
        return (k == OP_ALU) || (k == OP_LOAD);
    endfunction

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             req,
    input  logic [DEPTH-1:0] busy_vec,
    output logic [IDX_W-1:0] ptr_o,
    output logic             full_o,
    output logic             grant_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_nxt;

    always_comb begin
        ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        full_o  = busy_vec[ptr_q];
        grant_o = req && !full_o && !clr;
        ptr_o   = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr_q <= '0;
        else if (clr)     ptr_q <= '0;
        else if (grant_o) ptr_q <= ptr_nxt;
    end

    // R3: a refused or absent request leaves the allocation pointer unchanged
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_o && !clr) |=> $stable(ptr_q));

endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc_we,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  op_kind_t          alloc_kind,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic              cmp_vld,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic              rel_we,
    input  logic [IDX_W-1:0]  head_idx,
    output logic [DEPTH-1:0]  busy_vec,
    output logic [DEPTH-1:0]  done_vec,
    output rob_entry_t        head_o
);

    rob_entry_t [DEPTH-1:0] ent_flat;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_entry_t ent_q;
        logic       hit_alloc;
        logic       hit_cmp;
        logic       hit_rel;

        always_comb begin
            hit_alloc = alloc_we && (alloc_idx == IDX_W'(i));
            hit_cmp   = cmp_vld && (cmp_idx == IDX_W'(i)) && ent_q.busy;
            hit_rel   = rel_we && (head_idx == IDX_W'(i));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (clr) begin
                ent_q.busy <= 1'b0;
                ent_q.done <= 1'b0;
            end else if (hit_rel) begin
                ent_q.busy <= 1'b0;
                ent_q.done <= 1'b0;
            end else if (hit_alloc) begin
                ent_q.busy <= 1'b1;
                ent_q.kind <= alloc_kind;
                ent_q.done <= 1'b0;
                ent_q.dst  <= alloc_dst;
                ent_q.data <= '0;
            end else if (hit_cmp) begin
                ent_q.done <= 1'b1;
                ent_q.data <= cmp_data;
            end
        end

        assign ent_flat[i] = ent_q;
        assign busy_vec[i] = ent_q.busy;
        assign done_vec[i] = ent_q.done;
    end

    assign head_o = ent_flat[head_idx];

    // R3: an accepted allocation leaves its slot in use
    p_alloc_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_we && !clr) |=> busy_vec[$past(alloc_idx)]);

    // R4: only in-use slots may hold a result
    p_done_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_vec & ~busy_vec) == '0));

    // R4: completion into an idle slot does not mark it done
    p_idle_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld && !busy_vec[cmp_idx] && !(alloc_we && alloc_idx == cmp_idx))
        |=> !done_vec[$past(cmp_idx)]);

endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  rob_entry_t        head_i,
    output logic [IDX_W-1:0]  head_idx_o,
    output logic              rel_we_o,
    output logic              ret_fire,
    output logic              ret_we,
    output logic [IDX_W-1:0]  ret_idx,
    output logic [REG_W-1:0]  ret_dst,
    output logic [DATA_W-1:0] ret_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    rt_state_t         state_q;
    rt_state_t         state_nxt;
    logic              ready;
    logic [IDX_W-1:0]  head_q;
    op_kind_t          kind_q;
    logic [IDX_W-1:0]  idx_q;
    logic [REG_W-1:0]  dst_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        ready      = head_i.busy && head_i.done;
        rel_we_o   = ready && !clr;
        head_idx_o = head_q;
        state_nxt  = ready ? RT_EMIT : RT_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= RT_IDLE;
        else if (clr) state_q <= RT_IDLE;
        else          state_q <= state_nxt;
    end

    // head pointer and captured entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            kind_q <= OP_ALU;
            idx_q  <= '0;
            dst_q  <= '0;
            data_q <= '0;
        end else if (clr) begin
            head_q <= '0;
        end else if (ready) begin
            head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
            kind_q <= head_i.kind;
            idx_q  <= head_q;
            dst_q  <= head_i.dst;
            data_q <= head_i.data;
        end
    end

    // outputs
    always_comb begin
        ret_fire = 1'b0;
        ret_we   = 1'b0;
        ret_idx  = '0;
        ret_dst  = '0;
        ret_data = '0;
        unique case (state_q)
            RT_IDLE: ;
            RT_EMIT: begin
                ret_fire = 1'b1;
                ret_we   = writes_reg(kind_q);
                ret_idx  = idx_q;
                ret_dst  = dst_q;
                ret_data = data_q;
            end
            default: ;
        endcase
    end

    // R5: the head does not move while the oldest slot is unfinished
    p_head_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !clr) |=> $stable(head_q));

    // R6: a release is shown only after a done head slot was seen
    p_fire_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |-> ($past(head_i.done) && $past(head_i.busy)));

    // R7: the write strobe is never raised outside a release
    p_we_in_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_we |-> ret_fire);

endmodule

// File: rtl/rob_inorder.sv
module rob_inorder
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc_req,
    input  logic [1:0]        alloc_kind,
    input  logic [REG_W-1:0]  alloc_dst,
    output logic              alloc_ok,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              rob_full,
    input  logic              cmp_vld,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_data,
    output logic              ret_fire,
    output logic              ret_we,
    output logic [IDX_W-1:0]  ret_idx,
    output logic [REG_W-1:0]  ret_dst,
    output logic [DATA_W-1:0] ret_data
);

    logic [DEPTH-1:0] busy_vec;
    logic [DEPTH-1:0] done_vec;
    logic [IDX_W-1:0] head_idx;
    logic             rel_we;
    rob_entry_t       head_ent;

    rob_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .req      (alloc_req),
        .busy_vec (busy_vec),
        .ptr_o    (alloc_idx),
        .full_o   (rob_full),
        .grant_o  (alloc_ok)
    );

    rob_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .alloc_we   (alloc_ok),
        .alloc_idx  (alloc_idx),
        .alloc_kind (op_kind_t'(alloc_kind)),
        .alloc_dst  (alloc_dst),
        .cmp_vld    (cmp_vld),
        .cmp_idx    (cmp_idx),
        .cmp_data   (cmp_data),
        .rel_we     (rel_we),
        .head_idx   (head_idx),
        .busy_vec   (busy_vec),
        .done_vec   (done_vec),
        .head_o     (head_ent)
    );

    rob_retire #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_retire (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .head_i     (head_ent),
        .head_idx_o (head_idx),
        .rel_we_o   (rel_we),
        .ret_fire   (ret_fire),
        .ret_we     (ret_we),
        .ret_idx    (ret_idx),
        .ret_dst    (ret_dst),
        .ret_data   (ret_data)
    );

    // R9: after a clear no slot remains in use
    p_clr_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (busy_vec == '0));

endmodule

// File: tb/rob_inorder_bench.sv
module rob_inorder_bench;

    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              alloc_req = 1'b0;
    logic [1:0]        alloc_kind = '0;
    logic [2:0]        alloc_dst = '0;
    logic              alloc_ok;
    logic [IDX_W-1:0]  alloc_idx;
    logic              rob_full;
    logic              cmp_vld = 1'b0;
    logic [IDX_W-1:0]  cmp_idx = '0;
    logic [15:0]       cmp_data = '0;
    logic              ret_fire;
    logic              ret_we;
    logic [IDX_W-1:0]  ret_idx;
    logic [2:0]        ret_dst;
    logic [15:0]       ret_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int n_log = 0;
    int log_idx [64];
    int log_dst [64];
    int log_data [64];
    int log_we [64];
    int log_cyc [64];
    int exp_kind [DEPTH];
    int exp_dst [DEPTH];

    rob_inorder #(.DEPTH(DEPTH)) u_rob_inorder (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .alloc_req(alloc_req), .alloc_kind(alloc_kind), .alloc_dst(alloc_dst),
        .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .rob_full(rob_full),
        .cmp_vld(cmp_vld), .cmp_idx(cmp_idx), .cmp_data(cmp_data),
        .ret_fire(ret_fire), .ret_we(ret_we), .ret_idx(ret_idx),
        .ret_dst(ret_dst), .ret_data(ret_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        if (rst_n && ret_fire && n_log < 64) begin
            log_idx[n_log]  = int'(ret_idx);
            log_dst[n_log]  = int'(ret_dst);
            log_data[n_log] = int'(ret_data);
            log_we[n_log]   = int'(ret_we);
            log_cyc[n_log]  = cyc;
            n_log++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic alloc_one(input int kind, input int dst, input int exp_idx);
        alloc_req = 1'b1; alloc_kind = 2'(kind); alloc_dst = 3'(dst);
        #1;
        chk(alloc_ok == 1'b1, "R2 alloc_ok", int'(alloc_ok), 1);
        chk(int'(alloc_idx) == exp_idx, "R2 alloc_idx", int'(alloc_idx), exp_idx);
        exp_kind[exp_idx] = kind; exp_dst[exp_idx] = dst;
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic complete(input int idx, input int data);
        cmp_vld = 1'b1; cmp_idx = IDX_W'(idx); cmp_data = 16'(data);
        @(negedge clk);
        cmp_vld = 1'b0;
    endtask

    task automatic chk_log(input int k, input int idx, input int data, input string req);
        int we_exp;
        we_exp = (exp_kind[idx] < 2) ? 1 : 0;
        chk(log_idx[k] == idx, {req, " ret_idx"}, log_idx[k], idx);
        chk(log_data[k] == data, {req, " R4 ret_data"}, log_data[k], data);
        chk(log_dst[k] == exp_dst[idx], {req, " ret_dst"}, log_dst[k], exp_dst[idx]);
        chk(log_we[k] == we_exp, "R7 ret_we by kind", log_we[k], we_exp);
    endtask

    task automatic t_reset();
        chk(alloc_idx == '0, "R1 alloc_idx at reset", int'(alloc_idx), 0);
        chk(rob_full == 1'b0, "R1 rob_full at reset", int'(rob_full), 0);
        chk(ret_fire == 1'b0, "R1 ret_fire at reset", int'(ret_fire), 0);
    endtask

    task automatic t_reverse();
        alloc_one(0, 1, 0);
        alloc_one(2, 2, 1);
        alloc_one(1, 3, 2);
        complete(2, 16'hC003);
        complete(1, 16'hB002);
        idle(3);
        chk(n_log == 0, "R5 younger waits for head", n_log, 0);
        complete(0, 16'hA001);
        idle(6);
        chk(n_log == 3, "R6 three releases", n_log, 3);
        chk_log(0, 0, 16'hA001, "R5");
        chk_log(1, 1, 16'hB002, "R5");
        chk_log(2, 2, 16'hC003, "R5");
        chk(log_cyc[1] == log_cyc[0] + 1, "R6 consecutive", log_cyc[1], log_cyc[0] + 1);
        chk(log_cyc[2] == log_cyc[1] + 1, "R6 consecutive", log_cyc[2], log_cyc[1] + 1);
        chk(ret_fire == 1'b0, "R6 single-cycle pulse", int'(ret_fire), 0);
    endtask

    task automatic t_fill_wrap();
        complete(6, 16'hDEAD);
        idle(3);
        chk(n_log == 3, "R4 idle completion ignored", n_log, 3);
        for (int i = 0; i < DEPTH; i++) begin
            int s;
            s = (3 + i) % DEPTH;
            alloc_one(s % 4, (s + 4) % 8, s);
        end
        alloc_req = 1'b1;
        #1;
        chk(rob_full == 1'b1, "R3 rob_full", int'(rob_full), 1);
        chk(alloc_ok == 1'b0, "R3 alloc refused", int'(alloc_ok), 0);
        @(negedge clk);
        alloc_req = 1'b0;
        #1;
        chk(int'(alloc_idx) == 3, "R3 pointer held", int'(alloc_idx), 3);
        chk(n_log == 3, "R4 stale completion not released", n_log, 3);
        complete(3, 16'h3333);
        idle(2);
        chk(rob_full == 1'b0, "R8 slot freed", int'(rob_full), 0);
        chk(n_log == 4, "R8 one release", n_log, 4);
        chk_log(3, 3, 16'h3333, "R6");
        for (int j = 0; j < DEPTH - 1; j++) begin
            int s;
            s = (2 - j + DEPTH) % DEPTH;
            complete(s, 16'h1000 + s);
        end
        idle(10);
        chk(n_log == 11, "R10 all drained", n_log, 11);
        for (int k = 0; k < DEPTH - 1; k++) begin
            int s;
            s = (4 + k) % DEPTH;
            chk_log(4 + k, s, 16'h1000 + s, "R10 wrap order");
        end
    endtask

    task automatic t_clear();
        alloc_one(0, 6, 3);
        alloc_one(1, 7, 4);
        complete(4, 16'h4444);
        clr = 1'b1; alloc_req = 1'b1; alloc_kind = 2'd0; alloc_dst = 3'd1;
        cmp_vld = 1'b1; cmp_idx = IDX_W'(3); cmp_data = 16'h9999;
        @(negedge clk);
        clr = 1'b0; alloc_req = 1'b0; cmp_vld = 1'b0;
        #1;
        chk(alloc_idx == '0, "R1 alloc_idx after clear", int'(alloc_idx), 0);
        chk(rob_full == 1'b0, "R9 rob_full after clear", int'(rob_full), 0);
        idle(4);
        chk(n_log == 11, "R9 nothing released after clear", n_log, 11);
        alloc_one(0, 5, 0);
        complete(0, 16'h5555);
        idle(3);
        chk(n_log == 12, "R9 fresh entry released", n_log, 12);
        chk_log(11, 0, 16'h5555, "R9");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        #1;
        t_reset();
        idle(1);
        t_reverse();
        t_fill_wrap();
        t_clear();
        finish_run();
    end

endmodule